// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the countdown timer of a per-processor local interrupt controller. Software programs a timer entry (vector, mask and periodic bits), a divide setting and an initial count. The count then falls by one on every prescaled tick. When the countdown runs past zero, the block emits a one-cycle interrupt request that carries the programmed vector. Prioritisation, delivery and bus decoding are handled elsewhere.

The prescaler and the countdown restart whenever the initial count is written. A current-count register can be read back at any time. In one-shot mode the timer fires once and then rests at zero. In periodic mode it reloads and fires every initial+1 ticks. A zero initial count never fires. The mask bit silences the request but does not stop the count.

Top module: `lvt_countdown_timer`

## Requirements
- R1: After reset the timer entry reads 0x00010000 (masked, vector 0, one-shot), the initial count, divide and current count read 0, and no request is raised.
- R2: The count advances one tick every 2^N clocks from the initial-count write. The divide code is formed from register bits {3,1,0}: 000,001,010,011,100,101,110 give N=1..7 and 111 gives N=0.
- R3: Register select 0 is the timer entry (vector bits 7:0, mask bit 16, periodic bit 17). Select 1 is the initial count, and select 2 is the divide setting, which keeps only bits 3, 1 and 0. Select 3 is the current count, which is read-only: a write to it changes nothing.
- R4: In one-shot mode the count reads initial minus elapsed ticks and then holds at zero. Exactly one request is raised, on tick initial+1, and none after it.
- R5: In periodic mode a request is raised on every tick k*(initial+1), and the count goes back to the initial value at that tick. The count never exceeds the initial value.
- R6: An initial count of zero raises no request, in either mode.
- R7: While the mask bit is set, no request is raised, but the count keeps running. A one-shot expiry that falls while masked is lost and is not raised after unmasking.
- R8: A request is a single-cycle pulse, and the vector output carries the entry's vector during that cycle.
- R9: Writing the initial count loads the count, restarts the prescaler, and cancels any expiry pending from the previous load.
- R10: Changing the mode bit does not reset the count or the prescaler. A switch from one-shot to periodic before expiry makes the timer keep firing every initial+1 ticks from the original load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register select for the combinational read |
| rd_data | output | 32 | Read data |
| irq_pulse | output | 1 | One-cycle timer request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
The assertions assume that writes arrive as single-cycle strobes on a decoded select, and that any value may be written at any time, including a mode or divide change in mid-count. The pulse-width property relies on the nonzero initial count, which gives a shortest period of two ticks. The stimulus writes one register per cycle and changes the mode or mask only at chosen cycles relative to the load. The expected request times are therefore exact multiples of the tick length. Each scenario ends with the timer masked or quiet before the next load.

// File: rtl/lvt_countdown_timer.sv
module lvt_countdown_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        irq_pulse,
  output logic [7:0]  irq_vector
);
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;
  localparam int PRE_W    = 7;

  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q, armed_q;
  logic [2:0]       div_q;
  logic [CNT_W-1:0] init_q, cnt_q;
  logic [PRE_W-1:0] pre_q;

  logic wr_ent, wr_init, wr_div;
  assign wr_ent  = wr_en && (wr_sel == 2'd0);
  assign wr_init = wr_en && (wr_sel == 2'd1);
  assign wr_div  = wr_en && (wr_sel == 2'd2);

  logic [2:0]       shift;
  logic [PRE_W-1:0] pre_lim;
  assign shift   = div_q + 3'd1;
  assign pre_lim = PRE_W'((8'd1 << shift) - 8'd1);

  logic tick, at_zero, expire;
  assign tick    = pre_q >= pre_lim;
  assign at_zero = cnt_q == '0;
  assign expire  = tick && at_zero && (init_q != '0) && (per_q || armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q      <= '0;
      mask_q     <= 1'b1;
      per_q      <= 1'b0;
      div_q      <= '0;
      init_q     <= '0;
      cnt_q      <= '0;
      pre_q      <= '0;
      armed_q    <= 1'b0;
      irq_pulse  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= expire && !mask_q;
      if (expire && !mask_q) irq_vector <= 8'(vec_q);
      if (wr_ent) begin
        vec_q  <= wr_data[VEC_W-1:0];
        mask_q <= wr_data[MASK_BIT];
        per_q  <= wr_data[PER_BIT];
      end
      if (wr_div) div_q <= {wr_data[3], wr_data[1:0]};
      if (wr_init) begin
        init_q  <= wr_data[CNT_W-1:0];
        cnt_q   <= wr_data[CNT_W-1:0];
        pre_q   <= '0;
        armed_q <= wr_data[CNT_W-1:0] != '0;
      end else if (tick) begin
        pre_q <= '0;
        if (expire) begin
          if (per_q) cnt_q <= init_q;
          else       armed_q <= 1'b0;
        end else if (!at_zero) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd0:    rd_data = {14'b0, per_q, mask_q, 8'b0, 8'(vec_q)};
      2'd1:    rd_data = 32'(init_q);
      2'd2:    rd_data = {28'b0, div_q[2], 1'b0, div_q[1:0]};
      default: rd_data = 32'(cnt_q);
    endcase
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R8
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(mask_q)); // R7
  AST_ZERO_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(init_q) != '0); // R6
  AST_COUNT_LE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= init_q); // R5
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_q && at_zero && !wr_init) |=> cnt_q == '0); // R4
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wr_init |=> (cnt_q == $past(wr_data[CNT_W-1:0])) && (pre_q == '0)); // R9
endmodule

// File: tb/lvt_countdown_timer_test.sv
module lvt_countdown_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_pulse;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_c[$];
  logic [7:0] exp_v[$];

  lvt_countdown_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, output int c);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #1 c = cyc;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr0(input logic [1:0] sel, input logic [31:0] d);
    int c;
    wr(sel, d, c);
  endtask

  task automatic chk(input logic [1:0] sel, input logic [31:0] e, input string tag);
    rd_sel = sel; #1;
    checks++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s sel %0d got %h expected %h", tag, sel, rd_data, e);
    end
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(input int c, input logic [7:0] v);
    exp_c.push_back(c); exp_v.push_back(v);
  endtask

  always @(negedge clk) if (rst_n) begin
    if (exp_c.size() > 0 && exp_c[0] < cyc) begin
      checks++; errors++;
      $display("FAIL R4 R5 missing pulse at cycle %0d got none expected vector %h", exp_c[0], exp_v[0]);
      void'(exp_c.pop_front()); void'(exp_v.pop_front());
    end
    if (irq_pulse) begin
      checks++;
      if (exp_c.size() > 0 && exp_c[0] == cyc) begin
        if (irq_vector !== exp_v[0]) begin
          errors++;
          $display("FAIL R8 vector at cycle %0d got %h expected %h", cyc, irq_vector, exp_v[0]);
        end
        void'(exp_c.pop_front()); void'(exp_v.pop_front());
      end else begin
        errors++;
        $display("FAIL R6 R7 unexpected pulse at cycle %0d got vector %h expected no pulse", cyc, irq_vector);
      end
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog got hang expected completion");
    finish_run();
  end

  initial begin
    int c, c2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(0, 32'h0001_0000, "R1 entry");
    chk(1, 32'h0, "R1 initial");
    chk(2, 32'h0, "R1 divide");
    chk(3, 32'h0, "R1 count");
    checks++;
    if (irq_pulse !== 1'b0) begin errors++; $display("FAIL R1 pulse got %b expected 0", irq_pulse); end

    // R3 divide keeps bits 3,1,0; code 111 gives divide by 1
    wr0(2, 32'hFF);
    chk(2, 32'h0000_000B, "R3 divide bits");
    // R4 one-shot, div 1
    wr0(0, 32'h41);
    wr(1, 5, c);
    push(c + 6, 8'h41);
    wait_to(c + 2); chk(3, 3, "R4 count");
    wait_to(c + 20); chk(3, 0, "R4 hold zero");
    // R3 current count is read-only
    wr0(3, 32'h1234);
    chk(3, 0, "R3 count ro");
    chk(1, 5, "R3 initial kept");

    // R5 periodic, div 2
    wr0(0, 32'h0001_0000);
    wr0(2, 32'h0);
    wr(1, 3, c);
    wr0(0, 32'h0002_0052);
    push(c + 8, 8'h52); push(c + 16, 8'h52); push(c + 24, 8'h52);
    wait_to(c + 3); chk(3, 2, "R2 R5 count");
    wait_to(c + 7); chk(3, 0, "R5 reaches zero");
    wait_to(c + 9); chk(3, 3, "R5 reload");
    wait_to(c + 27);
    wr0(0, 32'h0003_0052);
    wait_to(c + 60);

    // R6 zero initial count, both modes
    wr0(1, 0);
    wr0(0, 32'h0002_0052);
    wait_to(cyc + 40); chk(3, 0, "R6 periodic zero");
    wr0(0, 32'h52);
    wait_to(cyc + 20); chk(3, 0, "R6 one-shot zero");

    // R2 divide by 16
    wr0(0, 32'h0001_0000);
    wr0(2, 32'h3);
    wr0(0, 32'h64);
    wr(1, 2, c);
    push(c + 48, 8'h64);
    wait_to(c + 15); chk(3, 2, "R2 before tick");
    wait_to(c + 16); chk(3, 1, "R2 first tick");
    wait_to(c + 60);
    // R2 divide by 128 (code 110)
    wr0(2, 32'hA);
    wr(1, 2, c);
    push(c + 384, 8'h64);
    wait_to(c + 127); chk(3, 2, "R2 div128 before");
    wait_to(c + 128); chk(3, 1, "R2 div128 tick");
    wait_to(c + 400);

    // R7 masked one-shot loses its expiry
    wr0(2, 32'hB);
    wr0(0, 32'h0001_0033);
    wr(1, 3, c);
    wait_to(c + 2); chk(3, 1, "R7 count runs");
    wait_to(c + 10);
    wr0(0, 32'h33);
    wait_to(cyc + 20); chk(3, 0, "R7 lost expiry");

    // R10 one-shot switched to periodic before expiry
    wr(1, 4, c);
    push(c + 5, 8'h33); push(c + 10, 8'h33);
    wait_to(c + 1);
    wr0(0, 32'h0002_0033);
    wait_to(c + 3); chk(3, 1, "R10 count kept");
    wait_to(c + 11);
    wr0(0, 32'h0003_0033);
    wait_to(c + 30);

    // R9 reload cancels the pending expiry
    wr0(0, 32'h77);
    wr(1, 6, c);
    wait_to(c + 3);
    wr(1, 3, c2);
    push(c2 + 4, 8'h77);
    wait_to(c2 + 1); chk(3, 2, "R9 restart count");
    wait_to(c2 + 20);

    checks++;
    if (exp_c.size() != 0) begin
      errors++;
      $display("FAIL R4 R5 leftover pulses got %0d expected 0", exp_c.size());
    end
    finish_run();
  end
endmodule